// File: doc/BRIEF.md
# ID Pin Resistor Code Debouncer

This block sits behind the converter that measures the resistance on a connector's identification pin. It asks for samples at a programmable rate, filters the stream of 5-bit resistor codes it receives, and reports one stable code to the rest of the chip. The first contact with an accessory needs a longer run of agreeing samples. Once the accessory is attached, a shorter run is enough to report a new code, for example a button press that switches in a different resistor.

A sample period is counted in ticks from a millisecond strobe. While the pin is floating and nothing is attached, the block stays idle: it requests no samples and ignores any that arrive. After attach, a disable input can stop code tracking to save power. A floating pin is still watched in that case, and it always causes a removal. A removal is reported as a change to code 0. A debounced code 0 has the same effect as a floating pin.

Top module: `id_code_debounce`

## Requirements
- R1: After reset, `code_out` is 0, `attached`, `attach_evt`, `change_evt` and `sample_req` are 0, and `float_o` is 1.
- R2: While the block is active, `sample_req` pulses once every P `ms_tick` pulses. P is set by `period_sel`: values 0 to 3 give 50, 100, 150 and 200; values 4 to 11 give 300 up to 1000 in steps of 100; values 12 to 15 give 1000.
- R3: While `id_float` is 1 and nothing is attached, no `sample_req` is issued and `smp_valid` samples have no effect.
- R4: When not attached, a non-zero code seen in `attach_cnt`+1 consecutive accepted samples sets `attached`, places the code on `code_out`, and pulses `attach_evt` for one cycle.
- R5: An accepted sample that differs from the current candidate makes that sample the new candidate, with a run length of one.
- R6: When attached, a code that differs from `code_out` and is seen in `change_cnt`+1 consecutive accepted samples is moved to `code_out` with a one-cycle `change_evt`.
- R7: When attached with `id_dis` at 1, no `sample_req` is issued, samples are ignored, and `code_out` holds its value.
- R8: When `id_float` is 1 while attached, whatever the value of `id_dis`, the next cycle shows `code_out` at 0, `attached` at 0 and a `change_evt` pulse.
- R9: When attached, a debounced code 0 is reported as a change to 0 and clears `attached`.
- R10: `float_o` equals `id_float` delayed by one clock.
- R11: `attach_evt` and `change_evt` are never high together, and `code_out` changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| period_sel | input | 4 | Sample period select |
| attach_cnt | input | 3 | Consecutive matches for first attach, minus one |
| change_cnt | input | 2 | Consecutive matches for a later change, minus one |
| id_dis | input | 1 | Stops code tracking after attach |
| id_float | input | 1 | Pin is floating (no resistance present) |
| smp_valid | input | 1 | Strobe for `smp_code` |
| smp_code | input | 5 | Measured resistor code |
| sample_req | output | 1 | Request for the next measurement |
| code_out | output | 5 | Reported stable code |
| attached | output | 1 | An accessory is attached |
| attach_evt | output | 1 | One-cycle pulse on first attach |
| change_evt | output | 1 | One-cycle pulse on a code change or a removal |
| float_o | output | 1 | Registered float flag |

## Verification
The filter is driven with three kinds of runs. Unbroken runs of one code show the exact threshold for each match count. Runs broken by a different code show that the count restarts, as opposed to accumulating across the break. Runs of the code already reported show that they cause no event. Removal is exercised twice: once through the float input with tracking disabled, and once through a debounced code 0. This separates the float path from the normal sampling path. The period is measured for codes from both the 50 ms steps and the 100 ms steps, and for one reserved code, which distinguishes the two arithmetic ranges from the clamp.

// File: rtl/idd_pkg.sv
package idd_pkg;

  localparam int MAX_PERIOD_MS = 1000;

  // Sample period in milliseconds for a period select value.
  function automatic int period_ms(input int sel);
    if (sel <= 3)       return 50 * (sel + 1);
    else if (sel <= 11) return 100 * (sel - 1);
    else                return MAX_PERIOD_MS;
  endfunction

  // A count field value n asks for n+1 agreeing samples.
  function automatic int match_need(input int field);
    return field + 1;
  endfunction

endpackage

// File: rtl/id_period_timer.sv
module id_period_timer #(
  parameter int PSEL_W = 4,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ms_tick,
  input  logic [PSEL_W-1:0] period_sel,
  output logic              sample_req
);
  logic [MS_W-1:0] ms_cnt;
  logic [MS_W-1:0] last_cnt;
  logic            wrap;

  assign last_cnt = MS_W'(idd_pkg::period_ms(int'(period_sel)) - 1);
  assign wrap     = ms_tick && (ms_cnt >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_cnt     <= '0;
      sample_req <= 1'b0;
    end else if (!run) begin
      ms_cnt     <= '0;
      sample_req <= 1'b0;
    end else begin
      sample_req <= wrap;
      if (ms_tick) ms_cnt <= wrap ? '0 : ms_cnt + MS_W'(1);
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt < MS_W'(idd_pkg::MAX_PERIOD_MS));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_req && ms_cnt == '0));
endmodule

// File: rtl/id_match_filter.sv
module id_match_filter #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [CNT_W-1:0]  need,
  input  logic              flush,
  output logic [CODE_W-1:0] cand_nxt,
  output logic              hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CODE_W-1:0] cand;
  logic [CNT_W-1:0]  cnt, cnt_nxt;

  always_comb begin
    cand_nxt = cand;
    cnt_nxt  = cnt;
    if (take) begin
      if (smp_code != cand) begin
        cand_nxt = smp_code;
        cnt_nxt  = CNT_W'(1);
      end else if (cnt != CNT_MAX) begin
        cnt_nxt = cnt + CNT_W'(1);
      end
    end
  end

  assign hit = take && (cnt_nxt >= need);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cand <= '0;
      cnt  <= '0;
    end else begin
      cand <= cand_nxt;
      cnt  <= cnt_nxt;
    end
  end

  // R5: a differing sample becomes the candidate with a run of one
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush && smp_code != cand) |=> (cnt == CNT_W'(1) && cand == $past(smp_code)));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flush) |=> ($stable(cnt) && $stable(cand)));
endmodule

// File: rtl/id_report_ctrl.sv
module id_report_ctrl #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [CODE_W-1:0] cand_nxt,
  input  logic              float_in,
  output logic [CODE_W-1:0] code_out,
  output logic              attached,
  output logic              attach_evt,
  output logic              change_evt,
  output logic              flush
);
  logic new_attach, new_change;

  assign flush      = attached && float_in;
  assign new_attach = hit && !attached && (cand_nxt != '0);
  assign new_change = hit && attached && (cand_nxt != code_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_out   <= '0;
      attached   <= 1'b0;
      attach_evt <= 1'b0;
      change_evt <= 1'b0;
    end else begin
      attach_evt <= 1'b0;
      change_evt <= 1'b0;
      if (flush) begin
        code_out   <= '0;
        attached   <= 1'b0;
        change_evt <= 1'b1;
      end else if (new_attach) begin
        code_out   <= cand_nxt;
        attached   <= 1'b1;
        attach_evt <= 1'b1;
      end else if (new_change) begin
        code_out   <= cand_nxt;
        change_evt <= 1'b1;
        if (cand_nxt == '0) attached <= 1'b0;
      end
    end
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(attach_evt && change_evt));
  a_r11_code_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_out) |-> (attach_evt || change_evt));
  a_r4_attach_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    attach_evt |-> (attached && code_out != '0));
  a_r9_zero_detaches: assert property (@(posedge clk) disable iff (!rst_n)
    (change_evt && code_out == '0) |-> !attached);
  a_r8_float_removal: assert property (@(posedge clk) disable iff (!rst_n)
    (attached && float_in) |=> (change_evt && !attached && code_out == '0));
endmodule

// File: rtl/id_code_debounce.sv
module id_code_debounce #(
  parameter int CODE_W = 5,
  parameter int PSEL_W = 4,
  parameter int ATT_W  = 3,
  parameter int CHG_W  = 2,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [PSEL_W-1:0] period_sel,
  input  logic [ATT_W-1:0]  attach_cnt,
  input  logic [CHG_W-1:0]  change_cnt,
  input  logic              id_dis,
  input  logic              id_float,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              sample_req,
  output logic [CODE_W-1:0] code_out,
  output logic              attached,
  output logic              attach_evt,
  output logic              change_evt,
  output logic              float_o
);
  localparam int CNT_W = ((ATT_W > CHG_W) ? ATT_W : CHG_W) + 1;

  logic              active;
  logic              take;
  logic [CNT_W-1:0]  need;
  logic [CODE_W-1:0] cand_nxt;
  logic              hit;
  logic              flush;
  logic              float_q;

  assign active  = !id_float && !(attached && id_dis);
  assign take    = smp_valid && active;
  assign need    = attached ? CNT_W'(idd_pkg::match_need(int'(change_cnt)))
                            : CNT_W'(idd_pkg::match_need(int'(attach_cnt)));
  assign float_o = float_q;

  always_ff @(posedge clk) begin
    if (!rst_n) float_q <= 1'b1;
    else        float_q <= id_float;
  end

  id_period_timer #(.PSEL_W(PSEL_W), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .ms_tick(ms_tick),
    .period_sel(period_sel), .sample_req(sample_req)
  );

  id_match_filter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .take(take), .smp_code(smp_code), .need(need),
    .flush(flush), .cand_nxt(cand_nxt), .hit(hit)
  );

  id_report_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cand_nxt(cand_nxt), .float_in(id_float),
    .code_out(code_out), .attached(attached), .attach_evt(attach_evt),
    .change_evt(change_evt), .flush(flush)
  );

  // R7: code tracking is frozen while disabled after attach
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (attached && id_dis && !id_float) |=> $stable(code_out));
  a_r10_float_hi: assert property (@(posedge clk) disable iff (!rst_n)
    id_float |=> float_o);
  a_r10_float_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !id_float |=> !float_o);
endmodule

// File: tb/id_code_debounce_tb.sv
module id_code_debounce_tb;
  typedef struct packed { logic is_attach; logic [4:0] code; } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [3:0] period_sel = 4'd0;
  logic [2:0] attach_cnt = 3'd3;
  logic [1:0] change_cnt = 2'd2;
  logic       id_dis = 1'b0;
  logic       id_float = 1'b1;
  logic       smp_valid = 1'b0;
  logic [4:0] smp_code = 5'd0;
  logic       sample_req, attached, attach_evt, change_evt, float_o;
  logic [4:0] code_out;

  int   n_checks = 0;
  int   n_fail = 0;
  int   tick_num = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  id_code_debounce u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .period_sel(period_sel),
    .attach_cnt(attach_cnt), .change_cnt(change_cnt), .id_dis(id_dis),
    .id_float(id_float), .smp_valid(smp_valid), .smp_code(smp_code),
    .sample_req(sample_req), .code_out(code_out), .attached(attached),
    .attach_evt(attach_evt), .change_evt(change_evt), .float_o(float_o)
  );

  // millisecond strobe: one cycle high every two cycles
  initial forever begin
    @(posedge clk); #2 ms_tick = 1'b1; tick_num++;
    @(posedge clk); #2 ms_tick = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (attach_evt || change_evt)) begin
      check(!(attach_evt && change_evt), "R11 single event", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected event", int'(code_out), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(attach_evt == e.is_attach && code_out == e.code, "R4/R6 event",
              int'({attach_evt, code_out}), int'({e.is_attach, e.code}));
      end
    end
  end

  task automatic expect_ev(input logic is_att, input logic [4:0] c);
    exp_t e;
    e.is_attach = is_att;
    e.code = c;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [4:0] c);
    @(negedge clk); smp_valid = 1'b1; smp_code = c;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic wait_req();
    do @(negedge clk); while (!sample_req);
  endtask

  task automatic measure(input logic [3:0] sel, input int exp_p);
    int t0;
    period_sel = sel;
    wait_req(); wait_req();
    t0 = tick_num;
    wait_req();
    check(tick_num - t0 == exp_p, "R2 period", tick_num - t0, exp_p);
  endtask

  task automatic count_req(input string req);
    int n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sample_req) n++;
    end
    check(n == 0, req, n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(code_out == 0 && !attached && !attach_evt && !change_evt && !sample_req,
          "R1 reset outputs", int'({attached, code_out}), 0);
    check(float_o == 1'b1, "R1 float_o", int'(float_o), 1);

    // R3 floating and unattached: idle
    count_req("R3 no request while floating");
    repeat (6) send(5'd5);
    check(!attached && code_out == 0, "R3 samples ignored", int'(code_out), 0);
    drain("R3 no events");

    // R10 float flag
    @(negedge clk); id_float = 1'b0;
    @(negedge clk);
    check(float_o == 1'b0, "R10 float_o low", int'(float_o), 0);

    // R5 restart on mismatch, then R4 attach with 4 matches
    send(5'd7); send(5'd7); send(5'd7);
    send(5'd9); send(5'd9); send(5'd9);
    check(!attached, "R5 run restarted", int'(attached), 0);
    expect_ev(1'b1, 5'd9);
    send(5'd9);
    check(attached && code_out == 5'd9, "R4 attach code", int'(code_out), 9);
    drain("R4 attach event seen");

    // R6 change with 3 matches, broken run restarts
    send(5'd12); send(5'd12);
    check(code_out == 5'd9, "R6 no early change", int'(code_out), 9);
    send(5'd3); send(5'd3);
    expect_ev(1'b0, 5'd3);
    send(5'd3);
    check(code_out == 5'd3, "R6 change code", int'(code_out), 3);
    send(5'd3); send(5'd3);
    drain("R6 events");

    // R7 disabled after attach
    @(negedge clk); id_dis = 1'b1;
    count_req("R7 no request while disabled");
    repeat (4) send(5'd20);
    check(code_out == 5'd3 && attached, "R7 code held", int'(code_out), 3);
    drain("R7 no events");

    // R8 float removal with id_dis still set
    expect_ev(1'b0, 5'd0);
    @(negedge clk); id_float = 1'b1;
    @(negedge clk); @(negedge clk);
    check(code_out == 0 && !attached, "R8 removal", int'({attached, code_out}), 0);
    check(float_o == 1'b1, "R10 float_o high", int'(float_o), 1);
    drain("R8 removal event");

    // R9 minimum counts, debounced code 0 removes
    @(negedge clk); id_dis = 1'b0; id_float = 1'b0; attach_cnt = 3'd0; change_cnt = 2'd0;
    expect_ev(1'b1, 5'd4);
    send(5'd4);
    check(attached && code_out == 5'd4, "R4 single-match attach", int'(code_out), 4);
    expect_ev(1'b0, 5'd0);
    send(5'd0);
    check(!attached && code_out == 0, "R9 code 0 removal", int'({attached, code_out}), 0);
    drain("R9 events");

    // R4 largest attach count: 8 matches
    @(negedge clk); attach_cnt = 3'd7;
    repeat (7) send(5'd2);
    check(!attached, "R4 seven matches not enough", int'(attached), 0);
    expect_ev(1'b1, 5'd2);
    send(5'd2);
    check(attached && code_out == 5'd2, "R4 eighth match attaches", int'(code_out), 2);
    drain("R4 events");

    // R2 periods
    measure(4'd0, 50);
    measure(4'd3, 200);
    measure(4'd4, 300);
    measure(4'd12, 1000);
    drain("R11 no stray events");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule